// File: doc/BRIEF.md
# Dual-Calendar Flow-Control Status Register Bank

This block is the host-facing control and status register bank for the receive side of a flow-control status channel. The channel runs from one of two calendar configurations. Each configuration has a repeat multiplier, a sequence length and a calendar RAM, which the host fills through an indirect address/data window. Because there are two configurations, the host can rewrite the idle calendar while the other one drives the channel. It then asks for a swap, and the swap happens without a glitch.

The frame generator pulses `frame_boundary` once per status frame. Two changes wait for that pulse: the active calendar select takes the requested value, and the forced-framing state takes the OR of its control bit and an external forcing input. The generator reads the active calendar's multiplier and length from ports, and reads calendar entries through a dedicated synchronous read port that always points at the active RAM. A register rule protects the calendar in use: a write to it while the channel is enabled is dropped and sets a sticky error flag.

Register addresses on `host_addr`: 0 identification, 1 control, 2 and 3 multipliers of calendars 0 and 1, 4 and 5 lengths of calendars 0 and 1, 6 indirect window address, 7 and 8 data windows of calendars 0 and 1, 9 to 15 unused.

Top module: `dual_cal_status_regs`

## Requirements
- R1: A read of address 0 returns the constant {BLOCK_ID[2:0], ID_CODE[12:0]}. With the default parameters this is 16'hAA5C. Writes to address 0 have no effect.
- R2: Addresses 9 to 15 read as zero and ignore writes. Control bits 4 and 7 to 15 read as zero.
- R3: The control register holds a forced-framing bit (bit 1) that resets to 1. The `framing_forced` output resets to 1 and changes only on a cycle with `frame_boundary` high. On that cycle it loads (bit 1 OR `force_framing_in`), and the new value shows after that clock edge.
- R4: Control bit 2 is the select request. On a `frame_boundary` cycle the active select (read-only control bit 3 and the `sel_active` output) loads the request. `sel_code` is 2'b01 for select 0 and 2'b10 for select 1.
- R5: Control bit 5 reads back the level of `chan_disabled` in the cycle of the read. Control bit 0 enables the select word and drives `sel_word_en`.
- R6: `act_mult` and `act_len` show the 8-bit multiplier and the 10-bit length of calendar `sel_active`.
- R7: A write to address 7 or 8 stores data bits 7:0 into that calendar's RAM at the 10-bit address held in register 6. A read of address 7 or 8 returns the RAM word at that address, zero-extended.
- R8: Writes to calendar 0 (addresses 2, 4, 7) are accepted only while `chan_disabled` is 1 or the active select is 1. A write that breaks this rule is dropped and sets control bit 6.
- R9: Writes to calendar 1 (addresses 3, 5, 8) are accepted only while `chan_disabled` is 1 or the active select is 0. A write that breaks this rule is dropped and sets control bit 6.
- R10: While control bit 0 is clear, addresses 3, 5 and 8 read as zero and ignore writes, and such writes do not set control bit 6.
- R11: Control bit 6 stays set until a control write with data bit 6 equal to 1 clears it.
- R12: `gen_rd_data` returns, one cycle after `gen_rd_addr` is presented, the word at that address in the calendar that was active in the presenting cycle.
- R13: Every host read returns its data on `host_rdata` in the cycle after `host_rd` is sampled high. A cycle never has `host_rd` and `host_wr` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Register address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, one cycle after the read |
| frame_boundary | input | 1 | One-cycle pulse at each status frame boundary |
| force_framing_in | input | 1 | External forced-framing request, ORed with control bit 1 |
| chan_disabled | input | 1 | Channel disabled status |
| gen_rd_addr | input | 10 | Generator read address into the active calendar |
| gen_rd_data | output | 8 | Generator read data, one cycle later |
| sel_active | output | 1 | Active calendar select |
| sel_code | output | 2 | Select word as sent on the channel |
| sel_word_en | output | 1 | Select word enabled in the status frame |
| framing_forced | output | 1 | Effective forced-framing state |
| act_mult | output | 8 | Active calendar multiplier |
| act_len | output | 10 | Active calendar length |

## Verification
The results fall into two timing groups. `sel_active`, `sel_code`, `framing_forced`, `act_mult`, `act_len` and `sel_word_en` come from registers, so they are due right after the clock edge that samples the write or the boundary pulse. `host_rdata` and `gen_rd_data` each pass one more register, so they are due one cycle after the read is sampled. The bench drives inputs on falling edges. On each rising edge its behavioural model updates its own state and records what the next read result should be. On each falling edge the bench compares the settled outputs with that state, and it compares `host_rdata` only in the cycle that follows a sampled read.

// File: rtl/scc_pkg.sv
package scc_pkg;

  localparam int unsigned HOST_W  = 16;
  localparam int unsigned NUM_CAL = 2;

  // register addresses; calendar 1 sits one above calendar 0
  localparam logic [3:0] A_ID     = 4'd0;
  localparam logic [3:0] A_CTRL   = 4'd1;
  localparam logic [3:0] A_MULT0  = 4'd2;
  localparam logic [3:0] A_LEN0   = 4'd4;
  localparam logic [3:0] A_WIN    = 4'd6;
  localparam logic [3:0] A_DAT0   = 4'd7;
  localparam logic [3:0] A_RSV_LO = 4'd9;

  // control register bit positions
  localparam int unsigned B_SEL_EN  = 0;
  localparam int unsigned B_FORCE   = 1;
  localparam int unsigned B_SEL_REQ = 2;
  localparam int unsigned B_SEL_ACT = 3;
  localparam int unsigned B_DIS     = 5;
  localparam int unsigned B_ERR     = 6;

  function automatic logic [1:0] sel_encode(input logic act);
    return act ? 2'b10 : 2'b01;
  endfunction

  // a calendar may change while the channel is disabled or while it is idle
  function automatic logic cal_writable(input int cal, input logic dis, input logic act);
    return dis || (act != (cal != 0));
  endfunction

  // calendar 1 exists only while the select word is enabled
  function automatic logic cal_present(input int cal, input logic sel_en);
    return (cal == 0) || sel_en;
  endfunction

  function automatic logic [HOST_W-1:0] pack_ctrl(input logic en, input logic frc,
                                                   input logic req, input logic act,
                                                   input logic dis, input logic err);
    logic [HOST_W-1:0] v;
    v = '0;
    v[B_SEL_EN]  = en;
    v[B_FORCE]   = frc;
    v[B_SEL_REQ] = req;
    v[B_SEL_ACT] = act;
    v[B_DIS]     = dis;
    v[B_ERR]     = err;
    return v;
  endfunction

endpackage

// File: rtl/scc_cal_ram.sv
module scc_cal_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          ra_en,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-before-write on both read ports
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (ra_en) ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end

endmodule

// File: rtl/scc_frame_sync.sv
module scc_frame_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_boundary,
  input  logic sel_req,
  input  logic force_reg,
  input  logic force_in,
  output logic sel_active,
  output logic framing_forced
);

  logic force_eff;
  assign force_eff = force_reg | force_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_active     <= 1'b0;
      framing_forced <= 1'b1;
    end else if (frame_boundary) begin
      sel_active     <= sel_req;
      framing_forced <= force_eff;
    end
  end

  p_forced_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_boundary |=> $stable(framing_forced));

  p_forced_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_boundary |=> framing_forced == ($past(force_reg) | $past(force_in)));

  p_sel_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_boundary |=> sel_active == $past(sel_req));

  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_boundary |=> $stable(sel_active));

endmodule

// File: rtl/scc_cal_cfg.sv
module scc_cal_cfg
  import scc_pkg::*;
#(
  parameter int unsigned MULT_W = 8,
  parameter int unsigned LEN_W  = 10
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr,
  input  logic [3:0]                       addr,
  input  logic [HOST_W-1:0]                wdata,
  input  logic                             sel_en,
  input  logic                             sel_active,
  input  logic                             chan_dis,
  output logic [NUM_CAL-1:0][MULT_W-1:0]   mult_o,
  output logic [NUM_CAL-1:0][LEN_W-1:0]    len_o,
  output logic [NUM_CAL-1:0]               dat_we,
  output logic                             viol
);

  logic [NUM_CAL-1:0] blocked;
  logic [NUM_CAL-1:0] absent_hit;

  for (genvar i = 0; i < NUM_CAL; i++) begin : g_cal
    localparam logic [3:0] MA = 4'(A_MULT0 + i);
    localparam logic [3:0] LA = 4'(A_LEN0 + i);
    localparam logic [3:0] DA = 4'(A_DAT0 + i);

    logic hit_m, hit_l, hit_d, present, ok;

    assign hit_m   = wr && (addr == MA);
    assign hit_l   = wr && (addr == LA);
    assign hit_d   = wr && (addr == DA);
    assign present = cal_present(i, sel_en);
    assign ok      = cal_writable(i, chan_dis, sel_active);

    assign blocked[i]    = (hit_m || hit_l || hit_d) && present && !ok;
    assign absent_hit[i] = (hit_m || hit_l || hit_d) && !present;
    assign dat_we[i]     = hit_d && present && ok;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mult_o[i] <= '0;
        len_o[i]  <= '0;
      end else begin
        if (hit_m && present && ok) mult_o[i] <= wdata[MULT_W-1:0];
        if (hit_l && present && ok) len_o[i]  <= wdata[LEN_W-1:0];
      end
    end

    // R8 for calendar 0, R9 for calendar 1
    p_cfg_guard_r8_r9: assert property (@(posedge clk) disable iff (!rst_n)
      blocked[i] |=> $stable(mult_o[i]) && $stable(len_o[i]));

    p_absent_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      absent_hit[i] |=> $stable(mult_o[i]) && $stable(len_o[i]));
  end

  assign viol = |blocked;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[HOST_W-1:LEN_W];

endmodule

// File: rtl/dual_cal_status_regs.sv
module dual_cal_status_regs
  import scc_pkg::*;
#(
  parameter int unsigned CAL_AW   = 10,
  parameter int unsigned ENTRY_W  = 8,
  parameter int unsigned MULT_W   = 8,
  parameter int unsigned LEN_W    = 10,
  parameter logic [12:0] ID_CODE  = 13'h0A5C,
  parameter logic [2:0]  BLOCK_ID = 3'd5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata,
  input  logic               frame_boundary,
  input  logic               force_framing_in,
  input  logic               chan_disabled,
  input  logic [CAL_AW-1:0]  gen_rd_addr,
  output logic [ENTRY_W-1:0] gen_rd_data,
  output logic               sel_active,
  output logic [1:0]         sel_code,
  output logic               sel_word_en,
  output logic               framing_forced,
  output logic [MULT_W-1:0]  act_mult,
  output logic [LEN_W-1:0]   act_len
);

  localparam int unsigned ENTRY_PAD = HOST_W - ENTRY_W;
  localparam int unsigned MULT_PAD  = HOST_W - MULT_W;
  localparam int unsigned LEN_PAD   = HOST_W - LEN_W;
  localparam int unsigned WIN_PAD   = HOST_W - CAL_AW;

  // control state
  logic              sel_en_q, force_q, sel_req_q, err_q;
  logic [CAL_AW-1:0] win_addr_q;

  // named internal events
  logic ctrl_wr, win_wr, rd_fire, err_clear, viol;
  logic [NUM_CAL-1:0]               dat_we, dat_rd, present;
  logic [NUM_CAL-1:0][MULT_W-1:0]   mult;
  logic [NUM_CAL-1:0][LEN_W-1:0]    len;
  logic [NUM_CAL-1:0][ENTRY_W-1:0]  ra_data, rb_data;

  assign ctrl_wr   = host_wr && (host_addr == A_CTRL);
  assign win_wr    = host_wr && (host_addr == A_WIN);
  assign rd_fire   = host_rd && !host_wr;
  assign err_clear = ctrl_wr && host_wdata[B_ERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_en_q   <= 1'b0;
      force_q    <= 1'b1;
      sel_req_q  <= 1'b0;
      err_q      <= 1'b0;
      win_addr_q <= '0;
    end else begin
      if (ctrl_wr) begin
        sel_en_q  <= host_wdata[B_SEL_EN];
        force_q   <= host_wdata[B_FORCE];
        sel_req_q <= host_wdata[B_SEL_REQ];
      end
      if (viol)           err_q <= 1'b1;
      else if (err_clear) err_q <= 1'b0;
      if (win_wr) win_addr_q <= host_wdata[CAL_AW-1:0];
    end
  end

  scc_frame_sync u_sync (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_boundary (frame_boundary),
    .sel_req        (sel_req_q),
    .force_reg      (force_q),
    .force_in       (force_framing_in),
    .sel_active     (sel_active),
    .framing_forced (framing_forced)
  );

  scc_cal_cfg #(.MULT_W(MULT_W), .LEN_W(LEN_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (host_wr),
    .addr       (host_addr),
    .wdata      (host_wdata),
    .sel_en     (sel_en_q),
    .sel_active (sel_active),
    .chan_dis   (chan_disabled),
    .mult_o     (mult),
    .len_o      (len),
    .dat_we     (dat_we),
    .viol       (viol)
  );

  for (genvar i = 0; i < NUM_CAL; i++) begin : g_ram
    localparam logic [3:0] DA = 4'(A_DAT0 + i);
    assign present[i] = cal_present(i, sel_en_q);
    assign dat_rd[i]  = rd_fire && (host_addr == DA) && present[i];

    scc_cal_ram #(.AW(CAL_AW), .DW(ENTRY_W)) u_ram (
      .clk     (clk),
      .we      (dat_we[i]),
      .waddr   (win_addr_q),
      .wdata   (host_wdata[ENTRY_W-1:0]),
      .ra_en   (dat_rd[i]),
      .ra_addr (win_addr_q),
      .ra_data (ra_data[i]),
      .rb_addr (gen_rd_addr),
      .rb_data (rb_data[i])
    );
  end

  // register read path
  logic [HOST_W-1:0]  reg_mux, reg_rdata_q;
  logic [NUM_CAL-1:0] dat_src_q;

  always_comb begin
    reg_mux = '0;
    case (host_addr)
      A_ID:   reg_mux = {BLOCK_ID, ID_CODE};
      A_CTRL: reg_mux = pack_ctrl(sel_en_q, force_q, sel_req_q, sel_active,
                                  chan_disabled, err_q);
      A_WIN:  reg_mux = {{WIN_PAD{1'b0}}, win_addr_q};
      default: reg_mux = '0;
    endcase
    for (int i = 0; i < NUM_CAL; i++) begin
      if (present[i] && host_addr == 4'(A_MULT0 + i))
        reg_mux = {{MULT_PAD{1'b0}}, mult[i]};
      if (present[i] && host_addr == 4'(A_LEN0 + i))
        reg_mux = {{LEN_PAD{1'b0}}, len[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata_q <= '0;
      dat_src_q   <= '0;
    end else if (rd_fire) begin
      reg_rdata_q <= reg_mux;
      dat_src_q   <= dat_rd;
    end
  end

  always_comb begin
    host_rdata = reg_rdata_q;
    for (int i = 0; i < NUM_CAL; i++)
      if (dat_src_q[i]) host_rdata = {{ENTRY_PAD{1'b0}}, ra_data[i]};
  end

  // generator side
  logic gen_sel_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gen_sel_q <= 1'b0;
    else        gen_sel_q <= sel_active;
  end

  assign gen_rd_data = rb_data[gen_sel_q];
  assign act_mult    = mult[sel_active];
  assign act_len     = len[sel_active];
  assign sel_code    = sel_encode(sel_active);
  assign sel_word_en = sel_en_q;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^host_wdata[HOST_W-1:CAL_AW];

  // assertions
  p_id_const_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && host_addr == A_ID) |=> host_rdata == {BLOCK_ID, ID_CODE});

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && host_addr >= A_RSV_LO) |=> host_rdata == '0);

  p_dis_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && host_addr == A_CTRL) |=> host_rdata[B_DIS] == $past(chan_disabled));

  p_code_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_code) == 1);

  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> err_q);

  p_masked_cal1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !sel_en_q && (host_addr == 4'(A_MULT0 + 1) ||
     host_addr == 4'(A_LEN0 + 1) || host_addr == 4'(A_DAT0 + 1))) |=> host_rdata == '0);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clear) |=> err_q);

  p_single_op_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && host_wr));

endmodule

// File: tb/dual_cal_status_regs_tb.sv
module dual_cal_status_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        frame_boundary = 1'b0, force_framing_in = 1'b0, chan_disabled = 1'b0;
  logic [9:0]  gen_rd_addr = '0;
  logic [7:0]  gen_rd_data;
  logic        sel_active, sel_word_en, framing_forced;
  logic [1:0]  sel_code;
  logic [7:0]  act_mult;
  logic [9:0]  act_len;

  always #5 clk = ~clk;

  dual_cal_status_regs u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .frame_boundary(frame_boundary), .force_framing_in(force_framing_in),
    .chan_disabled(chan_disabled), .gen_rd_addr(gen_rd_addr),
    .gen_rd_data(gen_rd_data), .sel_active(sel_active), .sel_code(sel_code),
    .sel_word_en(sel_word_en), .framing_forced(framing_forced),
    .act_mult(act_mult), .act_len(act_len)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit         m_en, m_force, m_req, m_act, m_forced, m_err;
  int         m_mult0, m_mult1, m_len0, m_len1, m_win;
  logic [7:0] mm0 [int];
  logic [7:0] mm1 [int];
  bit         rd_pend, rd_known, gen_known;
  int         rd_exp, gen_exp;
  string      rd_tag;

  function automatic bit allowed(input int cal);
    return chan_disabled || (cal == 0 ? m_act : !m_act);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_force = 1; m_req = 0; m_act = 0; m_forced = 1; m_err = 0;
      m_mult0 = 0; m_mult1 = 0; m_len0 = 0; m_len1 = 0; m_win = 0;
      rd_pend = 0; gen_known = 0;
    end else begin
      bit nx_act, nx_forced;
      // R13: host read result is due one cycle after the sampled read
      rd_pend = host_rd;
      if (host_rd) begin
        rd_known = 1; rd_exp = 0; rd_tag = "R13";
        case (host_addr)
          0: begin rd_exp = 16'hAA5C; rd_tag = "R1"; end
          1: begin rd_exp = {m_err, chan_disabled, 1'b0, m_act, m_req, m_force, m_en};
                   rd_tag = "R5/R8/R11 ctrl"; end
          2: begin rd_exp = m_mult0; rd_tag = "R8 mult0"; end
          3: begin rd_exp = m_en ? m_mult1 : 0; rd_tag = "R9/R10 mult1"; end
          4: begin rd_exp = m_len0; rd_tag = "R8 len0"; end
          5: begin rd_exp = m_en ? m_len1 : 0; rd_tag = "R9/R10 len1"; end
          6: begin rd_exp = m_win; rd_tag = "R7 win"; end
          7: begin rd_tag = "R7 dat0"; rd_known = mm0.exists(m_win);
                   if (rd_known) rd_exp = mm0[m_win]; end
          8: begin rd_tag = "R7/R10 dat1";
                   if (!m_en) rd_exp = 0;
                   else begin rd_known = mm1.exists(m_win); if (rd_known) rd_exp = mm1[m_win]; end
             end
          default: begin rd_exp = 0; rd_tag = "R2 reserved"; end
        endcase
      end
      // R12 generator port reads the calendar active now
      if (m_act) begin gen_known = mm1.exists(gen_rd_addr); if (gen_known) gen_exp = mm1[gen_rd_addr]; end
      else       begin gen_known = mm0.exists(gen_rd_addr); if (gen_known) gen_exp = mm0[gen_rd_addr]; end
      nx_act    = frame_boundary ? m_req : m_act;
      nx_forced = frame_boundary ? (m_force | force_framing_in) : m_forced;
      if (host_wr) begin
        case (host_addr)
          1: begin m_en = host_wdata[0]; m_force = host_wdata[1]; m_req = host_wdata[2];
                   if (host_wdata[6]) m_err = 0; end
          2: if (allowed(0)) m_mult0 = host_wdata[7:0]; else m_err = 1;
          4: if (allowed(0)) m_len0 = host_wdata[9:0]; else m_err = 1;
          7: if (allowed(0)) mm0[m_win] = host_wdata[7:0]; else m_err = 1;
          3: if (m_en) begin if (allowed(1)) m_mult1 = host_wdata[7:0]; else m_err = 1; end
          5: if (m_en) begin if (allowed(1)) m_len1 = host_wdata[9:0]; else m_err = 1; end
          8: if (m_en) begin if (allowed(1)) mm1[m_win] = host_wdata[7:0]; else m_err = 1; end
          6: m_win = host_wdata[9:0];
          default: ;
        endcase
      end
      m_act = nx_act; m_forced = nx_forced;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check("R3 framing_forced", 16'(framing_forced), 16'(m_forced));
      check("R4 sel_active", 16'(sel_active), 16'(m_act));
      check("R4 sel_code", 16'(sel_code), m_act ? 16'd2 : 16'd1);
      check("R5 sel_word_en", 16'(sel_word_en), 16'(m_en));
      check("R6 act_mult", 16'(act_mult), 16'(m_act ? m_mult1 : m_mult0));
      check("R6 act_len", 16'(act_len), 16'(m_act ? m_len1 : m_len0));
      if (rst_n && gen_known) check("R12 gen_rd_data", 16'(gen_rd_data), 16'(gen_exp));
      if (rst_n && rd_pend && rd_known) check(rd_tag, host_rdata, 16'(rd_exp));
    end
  end

  task automatic step();
    @(negedge clk);
    host_wr = 0; host_rd = 0; frame_boundary = 0;
  endtask

  task automatic wr(input int a, input int d);
    host_addr = 4'(a); host_wdata = 16'(d); host_wr = 1; step();
  endtask

  task automatic rd(input int a);
    host_addr = 4'(a); host_rd = 1; step();
  endtask

  task automatic bnd();
    frame_boundary = 1; step();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL R13 watchdog: actual hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // reset state and identification (R1, R2, R3)
    rd(0); rd(1); rd(2); rd(5);
    for (int a = 9; a < 16; a++) rd(a);
    wr(12, 16'hFFFF); wr(0, 16'h1234); rd(0); rd(12);
    // enable select word, release forced framing at a boundary (R3, R5)
    wr(1, 16'h0001); rd(1); step();
    bnd(); rd(1);
    // calendar 0 in use and channel enabled: blocked (R8)
    wr(2, 16'h33); rd(2); rd(1);
    wr(1, 16'h0041); rd(1);                       // R11 clear
    // fill calendar 1 while idle (R9 allowed, R7)
    wr(3, 16'h17); wr(5, 16'h2A5);
    for (int k = 0; k < 8; k++) begin wr(6, k); wr(8, 16'hA0 + k); end
    wr(6, 3); rd(8); rd(6);
    // request swap; nothing changes until the boundary (R4)
    wr(1, 16'h0005); step(); step(); rd(1);
    bnd(); rd(1);
    // calendar 0 now idle: writable, calendar 1 blocked (R8, R9)
    wr(2, 16'h44); wr(4, 16'h155);
    for (int k = 0; k < 8; k++) begin wr(6, k); wr(7, 16'h50 + k); end
    wr(3, 16'h99); rd(3); rd(1); wr(1, 16'h0045);
    for (int k = 0; k < 8; k++) begin gen_rd_addr = 10'(k); step(); end
    // disabled channel lifts the rule (R8, R9, R5)
    chan_disabled = 1; wr(3, 16'h66); wr(2, 16'h77); rd(3); rd(2); rd(1);
    chan_disabled = 0;
    // calendar 1 hidden when select word disabled (R10)
    wr(1, 16'h0004); rd(3); rd(5); wr(6, 2); rd(8); wr(3, 16'h11); rd(1);
    wr(1, 16'h0005); rd(3);
    // external forcing input (R3)
    force_framing_in = 1; step(); rd(1); bnd(); force_framing_in = 0; step(); bnd();
    // random traffic
    for (int n = 0; n < 1500; n++) begin
      int a, d;
      a = $urandom_range(0, 15);
      d = $urandom;
      if (a == 6) d = d & 7;
      chan_disabled    = ($urandom_range(0, 5) == 0);
      force_framing_in = ($urandom_range(0, 7) == 0);
      gen_rd_addr      = 10'($urandom_range(0, 7));
      frame_boundary   = ($urandom_range(0, 6) == 0);
      if ($urandom_range(0, 1) == 0) begin host_addr = 4'(a); host_wdata = 16'(d); host_wr = 1; end
      else begin host_addr = 4'(a); host_rd = 1; end
      step();
    end
    step(); step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule